// File: doc/BRIEF.md
# Boot ROM Overlay Memory Decoder

This block steers the memory accesses of an 8-bit CPU with a 16-bit address bus to one of two memories: a 16K-byte read-only boot store and a RAM that spans the full map. After reset the boot store covers addresses 0x0000 to 0x3FFF, so the CPU fetches its first code from it. A sticky disable flag removes that overlay later. From then on the RAM answers across the whole map, including the bottom quarter it used to share with the boot store.

All selection follows from one select line. That line is the OR of the two top address bits and the disable flag. The same line gives the boot store's active-low chip enable and the RAM's active-high chip select. As a result, exactly one memory is live at any moment. The block holds behavioural models of both memories and a registered read-data multiplexer, so it can be simulated on its own.

The boot store contents are computed rather than loaded. The RAM model keeps 2^RAM_IDX_W bytes (2K by default), indexed by the low address bits. Addresses that differ only above that index alias to the same byte.

Top module: `boot_overlay_dec`

## Requirements
- R1: While `rst_ni` is low, the disable flag clears and `rdata_o` reads 0x00. With the flag clear, any address below 0x4000 drives `ram_sel_o`=0, `rom_ce_no`=0 and `ram_cs_o`=0.
- R2: Any address with bit 15 or bit 14 set drives `ram_sel_o`=1, `rom_ce_no`=1 and `ram_cs_o`=1, whatever the state of the disable flag.
- R3: `rom_dis_i` high at a rising clock edge sets the disable flag. From the next cycle on, every address selects RAM.
- R4: Once set, the disable flag stays set while `rom_dis_i` is low, until the next reset. After that reset the overlay is active again.
- R5: At all times `rom_ce_no` and `ram_cs_o` both equal `ram_sel_o`. This means exactly one memory is enabled.
- R6: `rdata_o` after a rising edge holds the byte at the address presented at that edge. The byte comes from the memory selected in that cycle.
- R7: The boot store uses only address bits 13..0. Its byte at offset a is a[7:0] XOR {2'b10, a[13:8]}.
- R8: A write (`we_i`=1) in a cycle with `ram_sel_o`=1 stores `wdata_i` at RAM index addr[RAM_IDX_W-1:0], where the default index width is 11. Any address with the same low bits reads that byte back later.
- R9: A write in a cycle with `ram_sel_o`=0 changes no RAM byte.
- R10: A RAM read in the same cycle as a write to the same index returns the byte held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| we_i | input | 1 | Write enable |
| rom_dis_i | input | 1 | Strobe that switches the boot overlay off |
| rdata_o | output | 8 | Read data, one cycle after the address |
| ram_sel_o | output | 1 | Select line: 1 means RAM, 0 means boot store |
| rom_ce_no | output | 1 | Boot store chip enable, active low |
| ram_cs_o | output | 1 | RAM chip select, active high |

## Verification
Directed addresses at both edges of the 16K boundary, and at the top of the map, are run both with the overlay active and after it has been removed. This separates the address term of the select line from the flag term.

A full RAM fill, followed by writes under the overlay and at aliased upper addresses, shows whether a bottom-quarter write leaks into RAM and whether the index wraps correctly. A write and read to the same index in one cycle shows the read-before-write order.

Random address, data and write mixes run in two phases: one with the flag set, and one where a rare disable strobe lands partway through. These phases catch a flag that clears by itself or a read mux that picks the wrong memory.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
  localparam int unsigned CPU_AW = 16;
  localparam int unsigned DW     = 8;
  localparam int unsigned ROM_AW = 14;

  // computed boot store pattern
  function automatic logic [DW-1:0] rom_byte(input logic [ROM_AW-1:0] a);
    logic [ROM_AW-1:0] hi;
    hi = a >> 8;
    return a[7:0] ^ hi[7:0] ^ 8'h80;
  endfunction
endpackage

// File: rtl/ovl_decode.sv
module ovl_decode #(
  parameter int unsigned AW     = 16,
  parameter int unsigned ROM_AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rom_dis_i,
  output logic          ram_sel_o
);
  logic off_q;
  logic above_rom;

  assign above_rom = |addr_i[AW-1:ROM_AW];
  assign ram_sel_o = above_rom | off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        off_q <= 1'b0;
    else if (rom_dis_i) off_q <= 1'b1;
  end

  p_dis_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_dis_i |=> off_q);
  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |=> off_q);
endmodule

// File: rtl/ovl_rom.sv
module ovl_rom
  import boot_ovl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROM_AW-1:0] addr_i,
  output logic [DW-1:0]     rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rom_byte(addr_i);
  end
endmodule

// File: rtl/ovl_ram.sv
module ovl_ram #(
  parameter int unsigned IDX_W = 11,
  parameter int unsigned DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  localparam int unsigned DEPTH = 2 ** IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (cs_i && we_i) mem[idx_i] <= wdata_i;
  end

  // read-before-write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[idx_i];
  end
endmodule

// File: rtl/boot_overlay_dec.sv
module boot_overlay_dec
  import boot_ovl_pkg::*;
#(
  parameter int unsigned RAM_IDX_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CPU_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  input  logic              rom_dis_i,
  output logic [DW-1:0]     rdata_o,
  output logic              ram_sel_o,
  output logic              rom_ce_no,
  output logic              ram_cs_o
);
  logic          sel;
  logic          sel_q;
  logic [DW-1:0] rom_q;
  logic [DW-1:0] ram_q;

  ovl_decode #(.AW(CPU_AW), .ROM_AW(ROM_AW)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .rom_dis_i (rom_dis_i),
    .ram_sel_o (sel)
  );

  ovl_rom u_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i[ROM_AW-1:0]),
    .rdata_o (rom_q)
  );

  ovl_ram #(.IDX_W(RAM_IDX_W), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (addr_i[RAM_IDX_W-1:0]),
    .cs_i    (sel),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (ram_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel;
  end

  assign ram_sel_o = sel;
  assign rom_ce_no = sel;
  assign ram_cs_o  = sel;
  assign rdata_o   = sel_q ? ram_q : rom_q;

  p_upper_is_ram_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|addr_i[CPU_AW-1:ROM_AW]) |-> (ram_cs_o && rom_ce_no));
  p_rom_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_sel_o |=> (rdata_o == rom_byte($past(addr_i[ROM_AW-1:0]))));
  p_ram_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_sel_o |=> (rdata_o == ram_q));
endmodule

// File: tb/tb_boot_overlay_dec.sv
module tb_boot_overlay_dec;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 11;
  localparam int DEPTH = 2 ** IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic        dis = 1'b0;
  logic [7:0]  rdata;
  logic        ram_sel, rom_ce_n, ram_cs;

  boot_overlay_dec #(.RAM_IDX_W(IDX_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rom_dis_i(dis), .rdata_o(rdata), .ram_sel_o(ram_sel),
    .rom_ce_no(rom_ce_n), .ram_cs_o(ram_cs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   m_off;
  logic [7:0] m_ram [DEPTH];
  bit   m_known [DEPTH];
  bit   pend;
  logic [7:0] pend_val;
  string pend_req;

  function automatic logic [7:0] exp_rom(input logic [15:0] a);
    return a[7:0] ^ {2'b10, a[13:8]};
  endfunction

  function automatic bit exp_sel(input logic [15:0] a, input bit off);
    return a[15] | a[14] | off;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic w, input logic [7:0] wd,
                      input logic d, input string req);
    bit s;
    int idx;
    @(negedge clk);
    if (pend) chk(pend_req, "rdata_o", rdata, pend_val);
    addr = a; we = w; wdata = wd; dis = d;
    #1;
    s = exp_sel(a, m_off);
    chk(s ? "R2" : "R1", "ram_sel_o", ram_sel, s);
    chk("R5", "rom_ce_no", rom_ce_n, s);
    chk("R5", "ram_cs_o", ram_cs, s);
    idx = int'(a[IDX_W-1:0]);
    if (s) begin
      pend = m_known[idx];
      pend_val = m_ram[idx];
    end else begin
      pend = 1'b1;
      pend_val = exp_rom(a);
    end
    pend_req = req;
    if (s && w) begin
      m_ram[idx] = wd;
      m_known[idx] = 1'b1;
    end
    if (d) m_off = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; addr = '0; we = 1'b0; dis = 1'b0; wdata = '0;
    pend = 1'b0; m_off = 1'b0;
    #1;
    chk("R1", "ram_sel_o in reset", ram_sel, 1'b0);
    chk("R1", "rdata_o in reset", rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) m_known[i] = 1'b0;
    do_reset();
    // R7 boot store pattern at the edges of the overlay
    step(16'h0000, 0, 8'h00, 0, "R7");
    step(16'h3FFF, 0, 8'h00, 0, "R7");
    step(16'h1A5C, 0, 8'h00, 0, "R7");
    step(16'h4000, 0, 8'h00, 0, "R2");
    step(16'hFFFF, 0, 8'h00, 0, "R2");
    step(16'h2001, 0, 8'h00, 0, "R6");
    // R3 disable strobe
    step(16'h0000, 0, 8'h00, 1, "R3");
    step(16'h0000, 0, 8'h00, 0, "R3");
    // fill RAM through the bottom quarter
    for (int i = 0; i < DEPTH; i++)
      step(16'(i), 1, 8'($urandom), 0, "R8");
    for (int i = 0; i < 32; i++)
      step(16'($urandom), 0, 8'h00, 0, "R8");
    // R8 alias: write high, read low
    step(16'hC123, 1, 8'h3C, 0, "R8");
    step(16'h0123, 0, 8'h00, 0, "R8");
    // R10 same-cycle write then read
    step(16'h0456, 1, 8'hE7, 0, "R10");
    step(16'h0456, 0, 8'h00, 0, "R8");
    // R4 flag holds with strobe low
    for (int i = 0; i < 16; i++)
      step(16'(i * 16'h0101), 0, 8'h00, 0, "R4");
    // random, overlay off
    for (int i = 0; i < 2000; i++)
      step(16'($urandom), 1'($urandom), 8'($urandom), 0, "R6");
    // R4 reset restores overlay
    do_reset();
    step(16'h0010, 0, 8'h00, 0, "R4");
    // R9 writes under overlay must not reach RAM
    step(16'h0123, 1, 8'h55, 0, "R9");
    step(16'h0456, 1, 8'hAA, 0, "R9");
    step(16'h0000, 0, 8'h00, 1, "R9");
    step(16'h0123, 0, 8'h00, 0, "R9");
    step(16'h0456, 0, 8'h00, 0, "R9");
    // random with overlay on and a rare strobe
    do_reset();
    for (int i = 0; i < 2000; i++)
      step(16'($urandom), 1'($urandom), 8'($urandom),
           1'(($urandom % 700) == 0), "R6");
    @(negedge clk);
    if (pend) chk(pend_req, "rdata_o", rdata, pend_val);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule